// File: doc/BRIEF.md
# Serial Flash Page Write Sequencer

This block sits on the host side of a four-wire SPI link to a serial NOR flash that writes through an on-chip SRAM page buffer. A user request names a page, a starting byte offset inside that page and a byte count. The matching payload then arrives on a valid/ready byte stream. The sequencer performs three bus transactions for each request. It first fills the device buffer from the requested offset. It then tells the device to erase the page and program it from the buffer. Finally it reads the device status byte repeatedly until the self-timed operation reports ready, or until a programmable number of reads has been used up.

After reset the sequencer reads the status byte once, without being asked. From that read it learns whether the device uses 256-byte or 264-byte pages, and it checks the density field. Requests are refused until this start-up read has finished. The result of each request is reported as a one-cycle `done` pulse, or as a one-cycle `err` pulse together with a reason code.

Top module: `sfp_page_writer`

## Requirements
- R1: During and right after reset, `spi_cs_n` is 1, `spi_sck` is 0, and `cfg_valid`, `req_ready`, `done` and `err` are 0. The block then runs exactly one status read (opcode D7h followed by one dummy byte). It raises `cfg_valid` and sets `mode_264` to the inverse of status bit 0, where bit 0 = 1 means 256-byte pages.
- R2: If status bits 5..2 of the start-up read differ from the `DENSITY` parameter (0101), the block pulses `err` with `err_code` = 3.
- R3: The bus runs in SPI mode 0. `spi_sck` is low whenever `spi_cs_n` is high, and `spi_mosi` changes only while `spi_sck` is low. Bits go out most significant first. One SCK period lasts 2*`SCK_HALF` clock cycles.
- R4: A request whose page is `NUM_PAGES` or higher, whose offset is at or beyond the page size, or whose count (`req_count_m1`+1) exceeds the page size is refused. The block pulses `err` with `err_code` = 1 and does not touch the bus.
- R5: The buffer fill is one transaction: opcode 84h, then three address bytes, then the payload bytes in stream order. The offset sits in address bits 7..0 in 256-byte mode and in bits 8..0 in 264-byte mode. All other address bits are 0.
- R6: The program command is one transaction: opcode 83h, then three address bytes. These are the page shifted left by 8 in 256-byte mode and by 9 in 264-byte mode, with all other bits 0.
- R7: After the program command the block issues separate status reads until one returns bit 7 = 1 (ready). It then pulses `done`.
- R8: If `poll_limit` consecutive status reads all return bit 7 = 0, the block stops and pulses `err` with `err_code` = 2, after exactly `poll_limit` reads.
- R9: Between two transactions, `spi_cs_n` stays high for at least one SCK period.
- R10: `done` and `err` are single-cycle pulses and never high together.
- R11: `data_ready` is high only inside the buffer-fill transaction.
- R12: A fill that runs past the end of the page is still sent as one transaction without re-addressing, so the device continues storing from offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_page | input | PIN_W | Target page number |
| req_offset | input | OFF_W | First byte offset in the page |
| req_count_m1 | input | OFF_W | Byte count minus one |
| data_valid | input | 1 | Payload byte offered |
| data_ready | output | 1 | Payload byte taken this cycle when high with `data_valid` |
| data_byte | input | 8 | Payload byte |
| poll_limit | input | POLL_W | Maximum status reads after a program command |
| done | output | 1 | Request completed (pulse) |
| err | output | 1 | Request or start-up failed (pulse) |
| err_code | output | 2 | 1 bad request, 2 poll timeout, 3 density mismatch |
| cfg_valid | output | 1 | Start-up status read finished |
| mode_264 | output | 1 | Device uses 264-byte pages |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench builds the block with `SCK_HALF` = 1, so every byte costs only a few cycles. That keeps enough cycle budget to sweep page numbers from 0 to the last page, offsets up to the last byte of the page and byte counts up to a full page, in both page-size modes. A bus-level device model in the bench decodes every transaction. It reports busy for a configurable number of reads, so timeouts at and around `poll_limit` can be reached. `PIN_W` = 12 leaves room to present page numbers at and above `NUM_PAGES`.

// File: rtl/sfp_pkg.sv
`timescale 1ns/1ps
package sfp_pkg;
  typedef enum logic [1:0] {PH_STAT, PH_LOAD, PH_PROG, PH_POLL} phase_e;
  typedef enum logic [2:0] {ST_BOOT, ST_IDLE, ST_SEND, ST_WAIT, ST_GAP} state_e;

  localparam logic [7:0] CMD_BUF_FILL = 8'h84;
  localparam logic [7:0] CMD_COMMIT   = 8'h83;
  localparam logic [7:0] CMD_STATUS   = 8'hD7;

  localparam logic [1:0] ERR_REQ      = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT  = 2'd2;
  localparam logic [1:0] ERR_DENSITY  = 2'd3;
endpackage

// File: rtl/sfp_sck_shifter.sv
`timescale 1ns/1ps
module sfp_sck_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] tick;
  logic [2:0]    bitn;
  logic          busy;
  logic [7:0]    sh;
  logic          edge_now;

  assign edge_now = busy && (tick == CW'(HALF - 1));
  assign mosi     = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      bitn <= '0;
      busy <= 1'b0;
      sh   <= '0;
      sck  <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        sh   <= tx;
        tick <= '0;
        bitn <= '0;
        sck  <= 1'b0;
      end else if (busy) begin
        if (edge_now) begin
          tick <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfp_addr_pack.sv
`timescale 1ns/1ps
module sfp_addr_pack #(
  parameter int PAGE_BITS = 10,
  parameter int OFF_W     = 9,
  parameter int SMALL_W   = 8
) (
  input  logic                 mode_264,
  input  logic                 sel_page,
  input  logic [PAGE_BITS-1:0] page,
  input  logic [OFF_W-1:0]     off,
  output logic [23:0]          addr
);
  always_comb begin
    if (sel_page) begin
      addr = mode_264 ? (24'(page) << OFF_W) : (24'(page) << SMALL_W);
    end else begin
      addr = mode_264 ? 24'(off) : 24'(off[SMALL_W-1:0]);
    end
  end
endmodule

// File: rtl/sfp_poll_ctr.sv
`timescale 1ns/1ps
module sfp_poll_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sfp_page_writer.sv
`timescale 1ns/1ps
module sfp_page_writer
  import sfp_pkg::*;
#(
  parameter int          SCK_HALF   = 2,
  parameter int          NUM_PAGES  = 1024,
  parameter int          PIN_W      = 12,
  parameter int          OFF_W      = 9,
  parameter int          SMALL_PAGE = 256,
  parameter int          LARGE_PAGE = 264,
  parameter int          POLL_W     = 16,
  parameter logic [3:0]  DENSITY    = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PIN_W-1:0]  req_page,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [OFF_W-1:0]  req_count_m1,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic [7:0]        data_byte,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              cfg_valid,
  output logic              mode_264,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PAGE_BITS = $clog2(NUM_PAGES);
  localparam int SMALL_W   = $clog2(SMALL_PAGE);
  localparam int IDX_W     = OFF_W + 2;
  localparam int CMP_W     = OFF_W + 1;
  localparam int GAP_CYC   = 2 * SCK_HALF;
  localparam int GAP_W     = $clog2(GAP_CYC + 1);

  state_e               st;
  phase_e               ph;
  logic [IDX_W-1:0]     idx;
  logic [PAGE_BITS-1:0] page_q;
  logic [OFF_W-1:0]     off_q;
  logic [OFF_W-1:0]     cnt_q;
  logic [7:0]           status_q;
  logic [GAP_W-1:0]     gap;
  logic                 eng_start, eng_done;
  logic [7:0]           eng_tx, eng_rx;
  logic [23:0]          addr;
  logic [7:0]           tx_next;
  logic                 need_data, last_byte;
  logic [CMP_W-1:0]     psize;
  logic                 bad_req, gap_end, poll_clr, poll_step, poll_last;
  logic                 unused_status;

  assign unused_status = status_q[6] ^ status_q[1];

  sfp_sck_shifter #(.HALF(SCK_HALF)) u_sck (
    .clk(clk), .rst(rst), .start(eng_start), .tx(eng_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(eng_done), .rx(eng_rx));

  sfp_addr_pack #(.PAGE_BITS(PAGE_BITS), .OFF_W(OFF_W), .SMALL_W(SMALL_W)) u_addr (
    .mode_264(mode_264), .sel_page(ph == PH_PROG), .page(page_q), .off(off_q), .addr(addr));

  sfp_poll_ctr #(.W(POLL_W)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .step(poll_step), .limit(poll_limit), .last(poll_last));

  assign psize   = mode_264 ? CMP_W'(LARGE_PAGE) : CMP_W'(SMALL_PAGE);
  assign bad_req = (req_page >= PIN_W'(NUM_PAGES)) ||
                   ({1'b0, req_offset} >= psize) ||
                   (({1'b0, req_count_m1} + CMP_W'(1)) > psize);

  always_comb begin
    tx_next   = 8'h00;
    need_data = 1'b0;
    last_byte = 1'b0;
    unique case (ph)
      PH_LOAD: begin
        last_byte = (idx == (IDX_W'(cnt_q) + IDX_W'(4)));
        if (idx == '0)                tx_next = CMD_BUF_FILL;
        else if (idx < IDX_W'(4)) begin
          case (idx[1:0])
            2'd1:    tx_next = addr[23:16];
            2'd2:    tx_next = addr[15:8];
            default: tx_next = addr[7:0];
          endcase
        end else begin
          tx_next   = data_byte;
          need_data = 1'b1;
        end
      end
      PH_PROG: begin
        last_byte = (idx == IDX_W'(3));
        case (idx[1:0])
          2'd0:    tx_next = CMD_COMMIT;
          2'd1:    tx_next = addr[23:16];
          2'd2:    tx_next = addr[15:8];
          default: tx_next = addr[7:0];
        endcase
      end
      default: begin
        last_byte = (idx == IDX_W'(1));
        tx_next   = (idx == '0) ? CMD_STATUS : 8'h00;
      end
    endcase
  end

  assign data_ready = (st == ST_SEND) && need_data;
  assign req_ready  = (st == ST_IDLE) && cfg_valid;
  assign gap_end    = (st == ST_GAP) && (gap == GAP_W'(GAP_CYC - 1));
  assign poll_clr   = gap_end && (ph == PH_PROG);
  assign poll_step  = gap_end && (ph == PH_POLL) && !status_q[7] && !poll_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_BOOT;
      ph        <= PH_STAT;
      idx       <= '0;
      page_q    <= '0;
      off_q     <= '0;
      cnt_q     <= '0;
      status_q  <= '0;
      gap       <= '0;
      eng_start <= 1'b0;
      eng_tx    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= '0;
      cfg_valid <= 1'b0;
      mode_264  <= 1'b0;
      spi_cs_n  <= 1'b1;
    end else begin
      done      <= 1'b0;
      err       <= 1'b0;
      eng_start <= 1'b0;
      unique case (st)
        ST_BOOT: begin
          ph       <= PH_STAT;
          idx      <= '0;
          spi_cs_n <= 1'b0;
          st       <= ST_SEND;
        end
        ST_IDLE: begin
          if (req_valid && cfg_valid) begin
            if (bad_req) begin
              err      <= 1'b1;
              err_code <= ERR_REQ;
            end else begin
              page_q   <= req_page[PAGE_BITS-1:0];
              off_q    <= req_offset;
              cnt_q    <= req_count_m1;
              ph       <= PH_LOAD;
              idx      <= '0;
              spi_cs_n <= 1'b0;
              st       <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (!need_data || data_valid) begin
            eng_start <= 1'b1;
            eng_tx    <= tx_next;
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (eng_done) begin
            if (ph == PH_STAT || ph == PH_POLL) status_q <= eng_rx;
            if (last_byte) begin
              spi_cs_n <= 1'b1;
              gap      <= '0;
              st       <= ST_GAP;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_SEND;
            end
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            idx <= '0;
            unique case (ph)
              PH_STAT: begin
                cfg_valid <= 1'b1;
                mode_264  <= ~status_q[0];
                if (status_q[5:2] != DENSITY) begin
                  err      <= 1'b1;
                  err_code <= ERR_DENSITY;
                end
                st <= ST_IDLE;
              end
              PH_LOAD: begin
                ph       <= PH_PROG;
                spi_cs_n <= 1'b0;
                st       <= ST_SEND;
              end
              PH_PROG: begin
                ph       <= PH_POLL;
                spi_cs_n <= 1'b0;
                st       <= ST_SEND;
              end
              default: begin
                if (status_q[7]) begin
                  done <= 1'b1;
                  st   <= ST_IDLE;
                end else if (poll_last) begin
                  err      <= 1'b1;
                  err_code <= ERR_TIMEOUT;
                  st       <= ST_IDLE;
                end else begin
                  spi_cs_n <= 1'b0;
                  st       <= ST_SEND;
                end
              end
            endcase
          end else begin
            gap <= gap + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfp_chk.sv
`timescale 1ns/1ps
module sfp_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic data_ready,
  input logic done,
  input logic err,
  input logic cfg_valid,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst) !(done && err));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst) err |=> !err);
  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst) spi_cs_n |-> !spi_sck);
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && !spi_cs_n) |=> (!spi_sck || $stable(spi_mosi)));
  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst) $rose(spi_cs_n) |=> spi_cs_n);
  // R11
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst) data_ready |-> !spi_cs_n);
  // R1
  req_after_cfg_chk: assert property (@(posedge clk) disable iff (rst) req_ready |-> cfg_valid);
endmodule

bind sfp_page_writer sfp_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .data_ready(data_ready),
  .done(done), .err(err), .cfg_valid(cfg_valid), .spi_cs_n(spi_cs_n),
  .spi_sck(spi_sck), .spi_mosi(spi_mosi));

// File: tb/tb_sfp_page_writer.sv
`timescale 1ns/1ps
module tb_sfp_page_writer;
  localparam int HALF  = 1;
  localparam int PIN_W = 12;
  localparam int OFF_W = 9;
  localparam real TCLK = 5.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(TCLK/2) clk = ~clk;

  logic              req_valid = 0, data_valid = 0;
  logic [PIN_W-1:0]  req_page = '0;
  logic [OFF_W-1:0]  req_offset = '0, req_count_m1 = '0;
  logic [7:0]        data_byte = '0;
  logic [15:0]       poll_limit = 16'd8;
  logic              req_ready, data_ready, done, err, cfg_valid, mode_264;
  logic [1:0]        err_code;
  logic              spi_cs_n, spi_sck, spi_mosi;
  logic              spi_miso = 1'b0;

  sfp_page_writer #(.SCK_HALF(HALF), .PIN_W(PIN_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_offset(req_offset), .req_count_m1(req_count_m1),
    .data_valid(data_valid), .data_ready(data_ready), .data_byte(data_byte),
    .poll_limit(poll_limit), .done(done), .err(err), .err_code(err_code),
    .cfg_valid(cfg_valid), .mode_264(mode_264), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // ---------------- device model ----------------
  logic        m_pg256 = 1'b1;
  logic [3:0]  m_dens = 4'b0101;
  int          m_busy_cfg = 0, m_busy_left = 0;
  logic [7:0]  mbuf [0:263];
  logic [7:0]  mbytes [0:599];
  int          m_nb = 0, m_bits = 0, m_obit = 0;
  logic [7:0]  m_sh = '0, m_stat = '0;
  logic        m_rd = 1'b0;
  int          m_ntrans = 0, m_nstat = 0, m_nload = 0, m_nprog = 0, m_ndata = 0;
  logic [23:0] m_load_addr = '0, m_prog_addr = '0;
  realtime     t_rise = 0.0;
  int          gap_bad = 0;

  always @(negedge spi_cs_n) begin
    if (m_ntrans > 0 && ($realtime - t_rise) < 2*HALF*TCLK) gap_bad++;
    m_nb = 0; m_bits = 0; m_rd = 1'b0;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      m_sh = {m_sh[6:0], spi_mosi};
      m_bits++;
      if (m_bits == 8) begin
        if (m_nb < 600) mbytes[m_nb] = m_sh;
        m_nb++;
        m_bits = 0;
        if (m_nb == 1 && m_sh == 8'hD7) begin
          m_rd   = 1'b1;
          m_obit = 0;
          m_stat = {(m_busy_left == 0), 1'b0, m_dens, 1'b0, m_pg256};
        end
      end
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && m_rd) begin
      spi_miso = m_stat[7 - m_obit];
      m_obit   = (m_obit + 1) % 8;
    end
  end

  always @(posedge spi_cs_n) begin
    if (m_nb > 0) begin
      automatic int ps = m_pg256 ? 256 : 264;
      automatic logic [23:0] a = {mbytes[1], mbytes[2], mbytes[3]};
      automatic int o;
      m_ntrans++;
      if (mbytes[0] == 8'h84) begin
        m_nload++;
        m_load_addr = a;
        o = m_pg256 ? int'(a[7:0]) : int'(a[8:0]);
        m_ndata = m_nb - 4;
        for (int i = 4; i < m_nb; i++) begin
          mbuf[o] = mbytes[i];
          o = (o + 1) % ps;
        end
      end else if (mbytes[0] == 8'h83) begin
        m_nprog++;
        m_prog_addr = a;
        m_busy_left = m_busy_cfg;
      end else if (mbytes[0] == 8'hD7) begin
        m_nstat++;
        if (m_busy_left > 0) m_busy_left--;
      end
      t_rise = $realtime;
    end
  end

  // ---------------- checking helpers ----------------
  int nchk = 0, nerr = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int page, input int i);
    return 8'((page * 5) + (i * 29) + 7);
  endfunction

  task automatic do_req(input int page, input int off, input int cnt, output int res, output int fed);
    bit hs_d, hs_r;
    fed = 0;
    res = -1;
    @(negedge clk);
    req_page = PIN_W'(page); req_offset = OFF_W'(off); req_count_m1 = OFF_W'(cnt - 1);
    req_valid = 1'b1; data_valid = 1'b1; data_byte = pat(page, 0);
    for (int k = 0; k < 20000 && res == -1; k++) begin
      hs_d = data_valid && data_ready;
      hs_r = req_valid && req_ready;
      @(posedge clk); #1;
      if (hs_r) req_valid = 1'b0;
      if (hs_d) begin fed++; data_byte = pat(page, fed); end
      @(negedge clk);
      if (done) res = 0;
      else if (err) res = int'(err_code);
    end
    req_valid = 1'b0; data_valid = 1'b0;
    if (res == -1) begin
      nchk++; nerr++;
      $display("FAIL watchdog request page %0d: actual hung expected finish", page);
    end
  endtask

  task automatic do_reset(input logic pg256, input logic [3:0] dens, input int exp_err);
    int s0, seen;
    m_pg256 = pg256; m_dens = dens; m_busy_left = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n in reset", spi_cs_n, 1);
    chk("R1", "sck in reset", spi_sck, 0);
    chk("R1", "cfg_valid in reset", cfg_valid, 0);
    chk("R1", "req_ready in reset", req_ready, 0);
    chk("R10", "done/err in reset", done | err, 0);
    s0 = m_nstat;
    seen = 0;
    rst = 1'b0;
    for (int k = 0; k < 2000 && !cfg_valid; k++) begin
      @(negedge clk);
      if (err) seen = int'(err_code);
    end
    @(negedge clk);
    if (err) seen = int'(err_code);
    chk("R1", "cfg_valid after start-up", cfg_valid, 1);
    chk("R1", "start-up status reads", m_nstat - s0, 1);
    chk("R1", "mode_264", mode_264, !pg256);
    // R2 density check
    chk("R2", "start-up err code", seen, exp_err);
  endtask

  task automatic good_req(input int page, input int off, input int cnt, input int busy);
    int res, fed, nl, np, ns, ps, bad;
    ps = m_pg256 ? 256 : 264;
    m_busy_cfg = busy;
    nl = m_nload; np = m_nprog; ns = m_nstat;
    do_req(page, off, cnt, res, fed);
    chk("R7", "result", res, 0);
    chk("R5", "fill transactions", m_nload - nl, 1);
    chk("R12", "payload bytes in one fill", m_ndata, cnt);
    chk("R5", "stream bytes taken", fed, cnt);
    chk("R5", "fill address", m_load_addr, off);
    chk("R6", "program address", m_prog_addr, m_pg256 ? (page << 8) : (page << 9));
    chk("R6", "program transactions", m_nprog - np, 1);
    chk("R7", "status reads", m_nstat - ns, busy + 1);
    bad = 0;
    for (int i = 0; i < cnt; i++)
      if (mbuf[(off + i) % ps] !== pat(page, i)) bad++;
    chk("R5", "buffer byte mismatches", bad, 0);
  endtask

  task automatic bad_req(input int page, input int off, input int cnt);
    int res, fed, t0;
    t0 = m_ntrans;
    do_req(page, off, cnt, res, fed);
    // R4 rejection
    chk("R4", "refused request code", res, 1);
    chk("R4", "bus transactions on refusal", m_ntrans - t0, 0);
    chk("R11", "stream bytes taken on refusal", fed, 0);
  endtask

  int pages256 [5] = '{0, 1, 511, 1022, 1023};
  int offs256  [3] = '{0, 100, 255};
  int cnts256  [3] = '{1, 3, 8};
  int pages264 [3] = '{0, 700, 1023};
  int offs264  [3] = '{0, 200, 263};
  int cnts264  [2] = '{1, 5};
  bit finished = 0;

  initial begin
    int res, fed, ns, n;
    // 256-byte page device
    do_reset(1'b1, 4'b0101, 0);
    poll_limit = 16'd8;
    n = 0;
    foreach (pages256[p]) foreach (offs256[o]) foreach (cnts256[c]) begin
      good_req(pages256[p], offs256[o], cnts256[c], n % 3);
      n++;
    end
    good_req(300, 17, 256, 1);
    bad_req(1024, 0, 1);
    bad_req(4095, 0, 1);
    bad_req(5, 256, 1);
    bad_req(5, 0, 257);

    // R8 poll timeout and its edges
    poll_limit = 16'd3; m_busy_cfg = 5; ns = m_nstat;
    do_req(9, 0, 2, res, fed);
    chk("R8", "timeout code", res, 2);
    chk("R8", "reads before timeout", m_nstat - ns, 3);
    good_req(9, 4, 2, 2);
    poll_limit = 16'd1;
    good_req(10, 0, 1, 0);
    m_busy_cfg = 1; ns = m_nstat;
    do_req(11, 0, 1, res, fed);
    chk("R8", "timeout code at limit 1", res, 2);
    chk("R8", "reads at limit 1", m_nstat - ns, 1);
    poll_limit = 16'd8;

    // 264-byte page device
    do_reset(1'b0, 4'b0101, 0);
    n = 0;
    foreach (pages264[p]) foreach (offs264[o]) foreach (cnts264[c]) begin
      good_req(pages264[p], offs264[o], cnts264[c], n % 2);
      n++;
    end
    good_req(1, 10, 264, 0);
    bad_req(2, 264, 1);
    bad_req(2, 0, 265);
    bad_req(1024, 0, 1);

    // wrong density code
    do_reset(1'b1, 4'b0110, 3);

    chk("R9", "short chip-select gaps", gap_bad, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * TCLK);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog global: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule